// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a small, memory-programmed AND-OR array. Three primary inputs enter the array, and each input is offered to every product term in both its true and its inverted form. Each product term is the wired AND of whatever literals its configuration bits connect to it. The single output is the OR of all product terms. With three terms, the array can realise any three-input function that needs no more than three product terms.

The configuration is held in a serial chain of storage bits. The chain is loaded one bit per rising edge of the program clock while the program enable is high, most significant bit first. When the enable is low, the bits are held. While loading is in progress, the output is forced low. The function becomes valid once the enable drops.

A term with no literals connected evaluates to 1. A term that is not needed must therefore be programmed to a constant 0, by connecting both polarities of one input to it.

Top module: `sop_logic_array`

## Requirements
- R1: After reset, every configuration bit is 0, so all terms are empty and `f_out` is 1 for all eight values of `in_vec` while `prog_en` is low.
- R2: While `prog_en` is high, each rising edge of `pclk` shifts `prog_din` into bit 0 of the 18-bit configuration and moves every other bit up one place. After 18 edges, the first bit shifted sits in bit 17. Term t owns bits [6t+5:6t]. Within it, bit 6t+2i connects the true form of `in_vec[i]` and bit 6t+2i+1 connects its inverse.
- R3: A configuration bit of 1 connects its literal to its term, and a 0 leaves it unconnected. A term equals the AND of its connected literals.
- R4: `f_out` is the OR of the three product terms whenever `prog_en` is low.
- R5: A term with no literal connected evaluates to 1.
- R6: A term connected to both the true and the inverse form of the same input is 0 for every input value.
- R7: While `prog_en` is high, `f_out` is 0.
- R8: While `prog_en` is low, the configuration is held and `prog_din` has no effect on `f_out`.
- R9: Programmed with a = `in_vec[2]`, b = `in_vec[1]`, c = `in_vec[0]` as abc, a'c' and a forced-zero third term, the array outputs abc + a'c' for all eight inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Program clock for the configuration chain |
| prst_n | input | 1 | Asynchronous active-low reset, clears the configuration |
| prog_en | input | 1 | High to shift configuration bits in; output forced low |
| prog_din | input | 1 | Serial configuration data, MSB first |
| in_vec | input | 3 | Primary logic inputs |
| f_out | output | 1 | Sum-of-products result |

## Verification
A wrong stored bit is visible at `f_out` as soon as the enable falls, but only for input values that the faulty literal decides. For this reason the output is compared against the reference model for all eight input values after every load. A fault in the shift order shows up as a function that responds to the wrong input or polarity. Several single-literal loads, each aimed at a known bit position, expose this. A hold fault changes the output on the first clock edge at which `prog_din` differs from the stored data, and the model comparison on every clock catches it in that cycle.

// File: rtl/sop_pkg.sv
package sop_pkg;
   // two literals (true, inverse) per primary input
   localparam int unsigned POLARITIES = 2;

   function automatic int unsigned lit_pos(input int unsigned term_idx,
                                           input int unsigned inp_idx,
                                           input int unsigned n_inputs,
                                           input bit          inverted);
      return term_idx * (POLARITIES * n_inputs) + POLARITIES * inp_idx + (inverted ? 1 : 0);
   endfunction
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
   parameter int unsigned WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             ser_in,
   output logic [WIDTH-1:0] cfg_q
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sop_cfg_chain: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= '0;
      else if (shift_en) cfg_q <= {cfg_q[WIDTH-2:0], ser_in};
   end

   // R8: contents frozen whenever shifting is disabled
   p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(cfg_q))
      else $error("R8 configuration changed while idle");
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
   import sop_pkg::*;
#(
   parameter int unsigned N_IN    = 3,
   parameter int unsigned N_TERMS = 3,
   localparam int unsigned TERM_W = POLARITIES * N_IN,
   localparam int unsigned CFG_W  = TERM_W * N_TERMS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_IN-1:0]    in_vec,
   input  logic [CFG_W-1:0]   cfg,
   output logic [N_TERMS-1:0] terms
);
   generate
      if (N_IN < 1 || N_TERMS < 1) begin : g_bad_shape
         $error("sop_and_plane: need at least one input and one term");
      end

      for (genvar t = 0; t < N_TERMS; t++) begin : g_term
         logic [N_IN-1:0]   blocked;
         logic [TERM_W-1:0] mask;
         assign mask = cfg[t*TERM_W +: TERM_W];

         for (genvar i = 0; i < N_IN; i++) begin : g_inp
            logic use_true, use_inv;
            assign use_true   = cfg[lit_pos(t, i, N_IN, 1'b0)];
            assign use_inv    = cfg[lit_pos(t, i, N_IN, 1'b1)];
            // a connected literal that is currently 0 pulls the wired AND low
            assign blocked[i] = (use_true & ~in_vec[i]) | (use_inv & in_vec[i]);

            // R6: both polarities of one input force the term low
            p_contradiction_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
               (use_true && use_inv) |-> !terms[t])
               else $error("R6 contradictory term not zero");
         end

         assign terms[t] = ~|blocked;

         // R5: an empty term reads as 1
         p_empty_term_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mask == '0) |-> terms[t])
            else $error("R5 empty term not one");
      end
   endgenerate
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
   parameter int unsigned N_TERMS = 3
) (
   input  logic [N_TERMS-1:0] terms,
   input  logic               quiet,
   output logic               sum_out
);
   generate
      if (N_TERMS == 1) begin : g_single
         assign sum_out = terms[0] & ~quiet;
      end else begin : g_multi
         assign sum_out = (|terms) & ~quiet;
      end
   endgenerate
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
   import sop_pkg::*;
#(
   parameter int unsigned N_IN    = 3,
   parameter int unsigned N_TERMS = 3,
   localparam int unsigned CFG_W  = POLARITIES * N_IN * N_TERMS
) (
   input  logic            pclk,
   input  logic            prst_n,
   input  logic            prog_en,
   input  logic            prog_din,
   input  logic [N_IN-1:0] in_vec,
   output logic            f_out
);
   logic [CFG_W-1:0]   cfg;
   logic [N_TERMS-1:0] terms;

   sop_cfg_chain #(.WIDTH(CFG_W)) u_chain (
      .clk(pclk), .rst_n(prst_n), .shift_en(prog_en), .ser_in(prog_din), .cfg_q(cfg)
   );

   sop_and_plane #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_and (
      .clk(pclk), .rst_n(prst_n), .in_vec(in_vec), .cfg(cfg), .terms(terms)
   );

   sop_or_plane #(.N_TERMS(N_TERMS)) u_or (
      .terms(terms), .quiet(prog_en), .sum_out(f_out)
   );

   // R7: output silent during loading
   p_quiet_while_loading_r7: assert property (@(posedge pclk) disable iff (!prst_n)
      prog_en |-> !f_out)
      else $error("R7 output active during load");

   // R4: any live term drives the output high once loading ends
   p_or_any_term_r4: assert property (@(posedge pclk) disable iff (!prst_n)
      (!prog_en && terms != '0) |-> f_out)
      else $error("R4 live term not reflected");

   // R4: no live term leaves the output low
   p_or_no_term_r4: assert property (@(posedge pclk) disable iff (!prst_n)
      (terms == '0) |-> !f_out)
      else $error("R4 output high with no live term");
endmodule

// File: tb/tb_sop_logic_array.sv
module tb_sop_logic_array;
   logic       pclk = 1'b0;
   logic       prst_n = 1'b0;
   logic       prog_en = 1'b0;
   logic       prog_din = 1'b0;
   logic [2:0] in_vec = 3'd0;
   logic       f_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit compare_on = 1'b0;

   // behavioural model: queue of the last 18 bits shifted, oldest first
   bit model_q[$];

   always #5 pclk = ~pclk;

   sop_logic_array dut (
      .pclk(pclk), .prst_n(prst_n), .prog_en(prog_en),
      .prog_din(prog_din), .in_vec(in_vec), .f_out(f_out)
   );

   always @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         model_q.delete();
         for (int k = 0; k < 18; k++) model_q.push_back(1'b0);
      end else if (prog_en) begin
         model_q.push_back(prog_din);
         void'(model_q.pop_front());
      end
   end

   function automatic bit model_bit(int idx);
      return model_q[17 - idx];
   endfunction

   function automatic bit model_out(logic [2:0] x, bit en);
      bit any = 0;
      if (en) return 1'b0;
      for (int t = 0; t < 3; t++) begin
         bit prod = 1;
         for (int i = 0; i < 3; i++) begin
            if (model_bit(6*t + 2*i)     && !x[i]) prod = 0;
            if (model_bit(6*t + 2*i + 1) &&  x[i]) prod = 0;
         end
         if (prod) any = 1;
      end
      return any;
   endfunction

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s in_vec=%b actual=%b expected=%b", req, in_vec, act, exp);
      end
   endtask

   // clock-by-clock comparison with the model (R4, R2)
   always @(negedge pclk) begin
      if (compare_on && prst_n) begin
         #1 check("R4_model", f_out, model_out(in_vec, prog_en));
      end
   end

   task automatic load(logic [17:0] v);
      @(negedge pclk);
      #2 prog_en = 1'b1;
      for (int j = 17; j >= 0; j--) begin
         prog_din = v[j];
         @(negedge pclk);
         #2;
         if (j == 9) check("R7", f_out, 1'b0);
      end
      prog_en = 1'b0;
      prog_din = 1'b0;
   endtask

   task automatic sweep(string req, logic [7:0] truth);
      for (int x = 0; x < 8; x++) begin
         @(negedge pclk);
         #3 in_vec = 3'(x);
         #1 check(req, f_out, truth[x]);
         check({req, "_model"}, f_out, model_out(in_vec, prog_en));
      end
   endtask

   initial begin
      repeat (3) @(negedge pclk);
      prst_n = 1'b1;
      compare_on = 1'b1;
      sweep("R1", 8'hFF);

      // R9: abc + a'c' with a=in_vec[2], c=in_vec[0]; third term a contradiction on input 0
      load(18'b000011_100010_010101);
      sweep("R9", 8'b1000_0101);

      // R8: toggling data with enable low leaves the function alone
      for (int k = 0; k < 10; k++) begin
         @(negedge pclk);
         #2 prog_din = ~prog_din;
      end
      sweep("R8", 8'b1000_0101);

      // R5: third term left empty makes the output constant 1
      load(18'b000000_100010_010101);
      sweep("R5", 8'hFF);

      // R6: every term contradictory gives constant 0
      load(18'b000011_001100_110000);
      sweep("R6", 8'h00);

      // R2, R3: only bit 0 (true in_vec[0]) gives F = c
      load(18'b000011_000011_000001);
      sweep("R2", 8'b1010_1010);
      // R2, R3: only bit 5 (inverse in_vec[2]) gives F = a'
      load(18'b000011_000011_100000);
      sweep("R3", 8'b0000_1111);

      // R4: terms a and b ORed
      load(18'b000011_000100_010000);
      sweep("R4", 8'b1111_1100);

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge pclk);
         cyc++;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R1 watchdog actual=running expected=finished");
      end
      compare_on = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule